// File: doc/BRIEF.md
# Cache Configuration Tuner

The tuner searches the space of cache settings for one program phase. After a start pulse it drives a configuration made of three indices: cache size, associativity and line size. After each evaluation interval it takes one measured energy-delay figure over a valid/ready handshake. This figure is power times the square of the run time, given as an unsigned fixed-point number. The search is greedy and changes one parameter at a time. It doubles the current parameter until the figure gets worse or the range runs out, and then moves to the next parameter. It tracks the lowest figure seen and the configuration that produced it.

A separate pulse marks the end of each phase execution. These pulses are counted against a fixed budget, and tuning ends once the budget is spent. When tuning ends, the block presents the best configuration with a done flag and holds it until the next start. The first configuration tried is the one supplied at start, normally the configuration used most recently.

Index encodings:
- Size index: 0 = 2 KB, 1 = 4 KB, 2 = 8 KB.
- Ways index: 0 = direct mapped, 1 = 2-way, 2 = 4-way.
- Line index: 0 = 16 B, 1 = 32 B, 2 = 64 B.

Top module: `cfg_tuner`

## Requirements
- R1: A start pulse loads the starting configuration into the search, taking precedence over every other input in that cycle. Any index of 3 is lowered to 2, and the ways index is then lowered to the size index. The same pulse sets the best figure to all ones, clears the execution count and drops done, and the next cycle shows the loaded configuration.
- R2: Parameters are tuned in the order size, then ways, then line. Each trial step raises one index by one, which doubles that parameter. The first sample after start is the baseline for the starting configuration. Tuning of each new parameter begins from the best configuration found so far.
- R3: A parameter stops as soon as an accepted figure is strictly greater than the figure accepted before it. An equal figure lets the same parameter keep stepping.
- R4: Only configurations whose ways index does not exceed their size index are driven. A step that would reach index 3 or break that rule ends its parameter, and the search moves on to the next parameter. When no parameter can step, tuning finishes.
- R5: The best register takes the baseline sample and afterwards only a strictly lower figure, together with the configuration that produced it. Its value is visible on best_edp.
- R6: While searching, each phase_end pulse counts one execution. The pulse that brings the count to BUDGET (default 3) ends tuning.
- R7: When tuning ends, the cfg outputs show the best configuration, done is high and edp_ready is low. All of this holds, ignoring samples and phase_end, until the next start.
- R8: If a sample is accepted in the same cycle as the budget-ending phase_end, that sample is still compared and can become the best.
- R9: edp_ready is high exactly while searching and low after reset. A sample counts only when edp_valid and edp_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin tuning a phase |
| init_size | input | 2 | Starting size index |
| init_ways | input | 2 | Starting ways index |
| init_line | input | 2 | Starting line index |
| edp_valid | input | 1 | Measured figure is present |
| edp_data | input | EDP_W | Measured energy-delay figure, unsigned |
| edp_ready | output | 1 | Tuner accepts a figure |
| phase_end | input | 1 | One phase execution finished |
| cfg_size | output | 2 | Driven size index |
| cfg_ways | output | 2 | Driven ways index |
| cfg_line | output | 2 | Driven line index |
| done | output | 1 | Tuning finished, best configuration shown |
| best_edp | output | EDP_W | Lowest figure seen |

## Verification
An accepted figure and the budget-ending phase_end can land in the same cycle. The bench provokes this by keeping edp_valid high and pulsing phase_end on three consecutive cycles right after start, so the third pulse meets a sample that improves the best. It judges that the finished configuration and best_edp include that last sample. A second run drops edp_valid in the third cycle and expects the earlier best.

// File: rtl/cfg_tuner_pkg.sv
package cfg_tuner_pkg;
  typedef logic [1:0] idx_t;

  typedef struct packed {
    idx_t size;
    idx_t ways;
    idx_t line;
  } cache_cfg_t;

  typedef enum logic [1:0] {
    STG_SIZE = 2'd0,
    STG_WAYS = 2'd1,
    STG_LINE = 2'd2
  } stage_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_DONE   = 2'd2
  } fsm_t;

  localparam int   NUM_STG = 3;
  localparam idx_t IDX_TOP = 2'd2;
endpackage

// File: rtl/cfg_step.sv
module cfg_step
  import cfg_tuner_pkg::*;
(
  input  cache_cfg_t base,
  input  stage_t     stage,
  output cache_cfg_t next,
  output logic       ok
);
  always_comb begin
    next = base;
    ok   = 1'b0;
    case (stage)
      STG_SIZE: begin
        ok        = (base.size < IDX_TOP);
        next.size = base.size + 2'd1;
      end
      STG_WAYS: begin
        ok        = (base.ways < base.size);
        next.ways = base.ways + 2'd1;
      end
      STG_LINE: begin
        ok        = (base.line < IDX_TOP);
        next.line = base.line + 2'd1;
      end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/best_track.sv
module best_track
  import cfg_tuner_pkg::*;
#(
  parameter int EDP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  cache_cfg_t       clr_cfg,
  input  logic             ld,
  input  logic [EDP_W-1:0] edp,
  input  cache_cfg_t       cfg,
  output logic [EDP_W-1:0] best_edp,
  output cache_cfg_t       best_cfg
);
  logic             en;
  logic [EDP_W-1:0] edp_n;
  cache_cfg_t       cfg_n;

  always_comb begin
    en    = clr | ld;
    edp_n = clr ? {EDP_W{1'b1}} : edp;
    cfg_n = clr ? clr_cfg : cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_edp <= '0;
      best_cfg <= '0;
    end else if (en) begin
      best_edp <= edp_n;
      best_cfg <= cfg_n;
    end
  end
endmodule

// File: rtl/exec_budget.sv
module exec_budget #(
  parameter int BUDGET = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CNT_W = (BUDGET < 2) ? 1 : $clog2(BUDGET + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUDGET - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_n;
  logic             en;

  always_comb begin
    hit   = inc && (cnt == LAST);
    en    = clr | inc;
    cnt_n = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= cnt_n;
  end
endmodule

// File: rtl/cfg_tuner.sv
module cfg_tuner
  import cfg_tuner_pkg::*;
#(
  parameter int EDP_W  = 16,
  parameter int BUDGET = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       init_size,
  input  logic [1:0]       init_ways,
  input  logic [1:0]       init_line,
  input  logic             edp_valid,
  input  logic [EDP_W-1:0] edp_data,
  output logic             edp_ready,
  input  logic             phase_end,
  output logic [1:0]       cfg_size,
  output logic [1:0]       cfg_ways,
  output logic [1:0]       cfg_line,
  output logic             done,
  output logic [EDP_W-1:0] best_edp
);
  function automatic cache_cfg_t clamp_cfg(cache_cfg_t c);
    cache_cfg_t r;
    r = c;
    if (r.size > IDX_TOP) r.size = IDX_TOP;
    if (r.ways > IDX_TOP) r.ways = IDX_TOP;
    if (r.line > IDX_TOP) r.line = IDX_TOP;
    if (r.ways > r.size)  r.ways = r.size;
    return r;
  endfunction

  fsm_t             state, state_n;
  cache_cfg_t       cur_cfg, cur_n;
  stage_t           stage, stage_n;
  logic             first, first_n;
  logic [EDP_W-1:0] prev_edp, prev_n;
  logic             reg_en;

  cache_cfg_t       start_cfg;
  cache_cfg_t       best_cfg;
  cache_cfg_t       bcfg_n;
  logic [EDP_W-1:0] bedp_n;
  logic             acc, better, rose, keep_going;
  logic             budget_inc, budget_hit;

  cache_cfg_t       cur_step;
  logic             cur_ok;
  cache_cfg_t       alt_nx [NUM_STG];
  logic [NUM_STG-1:0] alt_ok;
  logic [1:0]       ns0;
  logic             alt_found;
  cache_cfg_t       alt_cfg;
  stage_t           alt_stage;

  assign start_cfg = clamp_cfg('{size: init_size, ways: init_ways, line: init_line});

  always_comb begin
    acc        = (state == ST_SEARCH) && edp_valid && !start;
    better     = first || (edp_data < best_edp);
    rose       = !first && (edp_data > prev_edp);
    bcfg_n     = better ? cur_cfg  : best_cfg;
    bedp_n     = better ? edp_data : best_edp;
    keep_going = !first && !rose && cur_ok;
    budget_inc = (state == ST_SEARCH) && phase_end && !start;
    ns0        = first ? 2'd0 : (2'(stage) + 2'd1);
  end

  // stepping the parameter under trial
  cfg_step u_cur_step (
    .base  (cur_cfg),
    .stage (stage),
    .next  (cur_step),
    .ok    (cur_ok)
  );

  // candidate first steps for each later parameter, from the best configuration
  for (genvar g = 0; g < NUM_STG; g++) begin : g_alt
    cfg_step u_alt_step (
      .base  (bcfg_n),
      .stage (stage_t'(g)),
      .next  (alt_nx[g]),
      .ok    (alt_ok[g])
    );
  end

  always_comb begin
    alt_found = 1'b0;
    alt_cfg   = bcfg_n;
    alt_stage = STG_SIZE;
    for (int g = NUM_STG - 1; g >= 0; g--) begin
      if (alt_ok[g] && (2'(g) >= ns0)) begin
        alt_found = 1'b1;
        alt_cfg   = alt_nx[g];
        alt_stage = stage_t'(g);
      end
    end
  end

  best_track #(.EDP_W(EDP_W)) u_best (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .clr_cfg  (start_cfg),
    .ld       (acc && better),
    .edp      (edp_data),
    .cfg      (cur_cfg),
    .best_edp (best_edp),
    .best_cfg (best_cfg)
  );

  exec_budget #(.BUDGET(BUDGET)) u_budget (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .inc   (budget_inc),
    .hit   (budget_hit)
  );

  // next-state logic
  always_comb begin
    state_n = state;
    cur_n   = cur_cfg;
    stage_n = stage;
    first_n = first;
    prev_n  = prev_edp;
    reg_en  = start || (state == ST_SEARCH);
    if (start) begin
      state_n = ST_SEARCH;
      cur_n   = start_cfg;
      stage_n = STG_SIZE;
      first_n = 1'b1;
      prev_n  = '0;
    end else if (state == ST_SEARCH) begin
      if (acc) begin
        first_n = 1'b0;
        if (keep_going) begin
          cur_n  = cur_step;
          prev_n = edp_data;
        end else if (alt_found) begin
          cur_n   = alt_cfg;
          stage_n = alt_stage;
          prev_n  = bedp_n;
        end else begin
          state_n = ST_DONE;
        end
      end
      if (budget_hit) state_n = ST_DONE;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_cfg  <= '0;
      stage    <= STG_SIZE;
      first    <= 1'b0;
      prev_edp <= '0;
    end else if (reg_en) begin
      state    <= state_n;
      cur_cfg  <= cur_n;
      stage    <= stage_n;
      first    <= first_n;
      prev_edp <= prev_n;
    end
  end

  cache_cfg_t out_cfg;
  always_comb begin
    out_cfg   = (state == ST_DONE) ? best_cfg : cur_cfg;
    edp_ready = (state == ST_SEARCH);
    done      = (state == ST_DONE);
    cfg_size  = out_cfg.size;
    cfg_ways  = out_cfg.ways;
    cfg_line  = out_cfg.line;
  end
endmodule

// File: rtl/cfg_tuner_chk.sv
module cfg_tuner_chk #(
  parameter int EDP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             edp_ready,
  input logic             done,
  input logic [1:0]       cfg_size,
  input logic [1:0]       cfg_ways,
  input logic [1:0]       cfg_line,
  input logic [EDP_W-1:0] best_edp
);
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (edp_ready && !done && (best_edp == {EDP_W{1'b1}})));

  p_legal_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edp_ready |-> ((cfg_ways <= cfg_size) && (cfg_size <= 2'd2) && (cfg_line <= 2'd2)));

  p_best_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((edp_ready || done) && !start) |=> (best_edp <= $past(best_edp)));

  p_done_no_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !edp_ready);

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(cfg_size) && $stable(cfg_ways) && $stable(cfg_line)));
endmodule

bind cfg_tuner cfg_tuner_chk #(.EDP_W(EDP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .edp_ready (edp_ready),
  .done      (done),
  .cfg_size  (cfg_size),
  .cfg_ways  (cfg_ways),
  .cfg_line  (cfg_line),
  .best_edp  (best_edp)
);

// File: tb/test_cfg_tuner.sv
`timescale 1ns/100ps
module test_cfg_tuner;
  localparam int EDP_W  = 16;
  localparam int BUDGET = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [1:0]       init_size, init_ways, init_line;
  logic             edp_valid;
  logic [EDP_W-1:0] edp_data;
  logic             edp_ready;
  logic             phase_end;
  logic [1:0]       cfg_size, cfg_ways, cfg_line;
  logic             done;
  logic [EDP_W-1:0] best_edp;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cfg_tuner #(.EDP_W(EDP_W), .BUDGET(BUDGET)) i_cfg_tuner (
    .clk(clk), .rst_n(rst_n), .start(start),
    .init_size(init_size), .init_ways(init_ways), .init_line(init_line),
    .edp_valid(edp_valid), .edp_data(edp_data), .edp_ready(edp_ready),
    .phase_end(phase_end),
    .cfg_size(cfg_size), .cfg_ways(cfg_ways), .cfg_line(cfg_line),
    .done(done), .best_edp(best_edp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // measured figure: bowl around a target, or flat
  int tgt_s = 2, tgt_w = 2, tgt_l = 2;
  bit flat = 1'b0;
  function automatic int iabs(int x); return (x < 0) ? -x : x; endfunction
  function automatic int edp_fn(int s, int w, int l);
    if (flat) return 500;
    return 100 + 40*iabs(s-tgt_s) + 25*iabs(w-tgt_w) + 10*iabs(l-tgt_l);
  endfunction

  always @(posedge clk) begin
    #1 edp_data <= EDP_W'(edp_fn(int'(cfg_size), int'(cfg_ways), int'(cfg_line)));
  end

  // ---------------- behavioural reference model ----------------
  int m_st;   // 0 idle, 1 searching, 2 finished
  int cs, cw, cl, bs, bw, bl;
  int m_best, m_prev, m_stg, m_cnt;
  bit m_first;

  function automatic bit m_can(int s, int w, int l, int p);
    if (p == 0) return s < 2;
    if (p == 1) return w < s;
    if (p == 2) return l < 2;
    return 1'b0;
  endfunction

  task automatic m_from(input int s, input int w, input int l, input int p0);
    bit found = 1'b0;
    for (int p = p0; p < 3; p++) begin
      if (!found && m_can(s, w, l, p)) begin
        found = 1'b1;
        cs = s; cw = w; cl = l;
        if (p == 0) cs++;
        if (p == 1) cw++;
        if (p == 2) cl++;
        m_stg = p;
      end
    end
    if (!found) m_st = 2;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; cs = 0; cw = 0; cl = 0; bs = 0; bw = 0; bl = 0;
      m_best = 0; m_prev = 0; m_stg = 0; m_cnt = 0; m_first = 1'b0;
    end else if (start) begin
      cs = (init_size > 2) ? 2 : int'(init_size);
      cw = (init_ways > 2) ? 2 : int'(init_ways);
      cl = (init_line > 2) ? 2 : int'(init_line);
      if (cw > cs) cw = cs;
      bs = cs; bw = cw; bl = cl;
      m_st = 1; m_best = (1 << EDP_W) - 1; m_prev = 0; m_stg = 0; m_cnt = 0; m_first = 1'b1;
    end else if (m_st == 1) begin
      int e;
      bit pe;
      e  = int'(edp_data);
      pe = phase_end;
      if (edp_valid) begin
        if (m_first) begin
          m_best = e; bs = cs; bw = cw; bl = cl; m_prev = e; m_first = 1'b0;
          m_from(cs, cw, cl, 0);
        end else begin
          if (e < m_best) begin m_best = e; bs = cs; bw = cw; bl = cl; end
          if (e > m_prev) begin
            m_prev = m_best; m_from(bs, bw, bl, m_stg + 1);
          end else if (m_can(cs, cw, cl, m_stg)) begin
            m_prev = e;
            if (m_stg == 0) cs++;
            if (m_stg == 1) cw++;
            if (m_stg == 2) cl++;
          end else begin
            m_prev = m_best; m_from(bs, bw, bl, m_stg + 1);
          end
        end
      end
      if (pe) begin
        m_cnt++;
        if (m_cnt >= BUDGET) m_st = 2;
      end
    end
  end

  bit wd_fired = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !wd_fired) begin
      int es, ew, el;
      es = (m_st == 2) ? bs : cs;
      ew = (m_st == 2) ? bw : cw;
      el = (m_st == 2) ? bl : cl;
      check(edp_ready == (m_st == 1), "R9 model ready", int'(edp_ready), int'(m_st == 1));
      check(done == (m_st == 2), "R7 model done", int'(done), int'(m_st == 2));
      check({cfg_size, cfg_ways, cfg_line} == {2'(es), 2'(ew), 2'(el)}, "R2 model cfg",
            int'({cfg_size, cfg_ways, cfg_line}), int'({2'(es), 2'(ew), 2'(el)}));
      check(int'(best_edp) == m_best, "R5 model best", int'(best_edp), m_best);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_start(input int s, input int w, input int l);
    init_size = 2'(s); init_ways = 2'(w); init_line = 2'(l);
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic wait_done(input int max_cyc);
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      if (done) break;
      tick();
    end
  endtask

  function automatic int cfgv(int s, int w, int l);
    return s*16 + w*4 + l;
  endfunction

  task automatic check_cfg(input string req, input int s, input int w, input int l);
    check({cfg_size, cfg_ways, cfg_line} == {2'(s), 2'(w), 2'(l)}, req,
          cfgv(int'(cfg_size), int'(cfg_ways), int'(cfg_line)), cfgv(s, w, l));
  endtask

  initial begin
    #(200000 * 5);
    wd_fired = 1'b1;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; edp_valid = 1'b0; phase_end = 1'b0;
    init_size = '0; init_ways = '0; init_line = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!edp_ready, "R9 reset ready", int'(edp_ready), 0);
    check(!done, "R7 reset done", int'(done), 0);
    tick();

    // R1: clamping of the starting configuration
    edp_valid = 1'b0;
    do_start(0, 3, 3);
    @(negedge clk);
    check_cfg("R1 clamp 0/3/3", 0, 0, 2);
    check(best_edp == {EDP_W{1'b1}}, "R1 best cleared", int'(best_edp), 65535);
    check(edp_ready && !done, "R1 searching", int'({edp_ready, done}), 2);
    tick();
    do_start(1, 2, 3);
    @(negedge clk);
    check_cfg("R1 clamp 1/2/3", 1, 1, 2);
    tick();

    // R2: full walk to the far corner
    tgt_s = 2; tgt_w = 2; tgt_l = 2; flat = 1'b0;
    do_start(0, 0, 0);
    edp_valid = 1'b1;
    wait_done(40);
    check(done, "R2 finished", int'(done), 1);
    check_cfg("R2 final cfg", 2, 2, 2);
    check(int'(best_edp) == 100, "R5 final best", int'(best_edp), 100);
    tick();

    // R3 / R4: rise stops size, ways step not buildable, line stops on rise
    tgt_s = 0; tgt_w = 0; tgt_l = 1;
    do_start(1, 1, 0);
    wait_done(40);
    check_cfg("R3 R4 final cfg", 1, 1, 1);
    check(int'(best_edp) == 165, "R3 final best", int'(best_edp), 165);
    tick();

    // R7: finished outputs held while samples and phase_end arrive
    for (int i = 0; i < 8; i++) begin
      edp_valid = i[0];
      phase_end = i[1];
      tick();
    end
    phase_end = 1'b0;
    edp_valid = 1'b1;
    @(negedge clk);
    check(done && !edp_ready, "R7 held done", int'({done, edp_ready}), 2);
    check_cfg("R7 held cfg", 1, 1, 1);
    tick();

    // R3 / R5: equal figures keep stepping, best stays on baseline
    flat = 1'b1;
    do_start(0, 0, 0);
    wait_done(40);
    check_cfg("R5 flat final cfg", 0, 0, 0);
    check(int'(best_edp) == 500, "R5 flat best", int'(best_edp), 500);
    flat = 1'b0;
    tick();

    // R8: budget-ending pulse together with an improving sample
    tgt_s = 2; tgt_w = 2; tgt_l = 2;
    do_start(0, 0, 0);
    phase_end = 1'b1;
    tick(); tick(); tick();
    phase_end = 1'b0;
    @(negedge clk);
    check(done, "R8 done after budget", int'(done), 1);
    check_cfg("R8 cfg includes last sample", 2, 0, 0);
    check(int'(best_edp) == 170, "R8 best includes last sample", int'(best_edp), 170);
    tick();

    // R6: budget reached on a cycle without a sample
    do_start(0, 0, 0);
    phase_end = 1'b1;
    tick(); tick();
    edp_valid = 1'b0;
    tick();
    phase_end = 1'b0;
    @(negedge clk);
    check(done, "R6 done after budget", int'(done), 1);
    check_cfg("R6 best cfg", 1, 0, 0);
    check(int'(best_edp) == 210, "R6 best", int'(best_edp), 210);
    tick();

    // R1: restart during a search
    edp_valid = 1'b1;
    do_start(0, 0, 0);
    tick(); tick();
    do_start(2, 2, 0);
    @(negedge clk);
    check_cfg("R1 restart cfg", 2, 2, 0);
    check(!done && best_edp == {EDP_W{1'b1}}, "R1 restart clears", int'(done), 0);
    tick();
    wait_done(40);
    check_cfg("R2 restart final", 2, 2, 2);
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule